// File: doc/BRIEF.md
# Critical Section Call Queue

This block sits between a group of small cores and one shared large core that runs critical sections for them. A small core that reaches a critical section does not take the lock itself. It posts a call into this queue and then waits for a return pulse. A call carries the lock address, the code address to run and the caller's stack pointer. The queue adds the caller's core number from the port the call arrived on.

Calls are queued in the order they are accepted. The large core pulls them one at a time over a valid/ready port. The queue records which call is in service. When the large core reports completion, the queue sends a one-cycle return pulse to the core that made that call, and the pulse carries the lock address back with it.

Back-pressure rules:
- On the call side, a core's ready is high only in the cycle it wins arbitration. Ready depends on that core's own valid, so a core must hold valid and its fields steady until it sees ready.
- On the large-core side, the head entry stays presented and unchanged until ready is sampled high.

Top module: `crit_call_queue`

## Requirements
- R1: A synchronous active-high reset empties the queue, clears the in-service record and clears the error flag. In the cycle after reset is released, `exec_valid`, `ret_pulse` and `err_stray` are low, and the arbitration pointer gives core 0 first priority.
- R2: At most one call is accepted per cycle. A call from core i is accepted when `call_valid[i]` and `call_ready[i]` are both high at a clock edge.
- R3: A core with an outstanding call sees `call_ready` low until its return pulse has been issued. From the cycle of that pulse onward it can be accepted again.
- R4: When several cores without outstanding calls present valid, ready goes to the first of them found by counting upward, with wrap-around, starting at the core after the one most recently accepted.
- R5: Entries reach the large-core port in acceptance order. On that port, `exec_core` is the index of the call port the entry came in on, and `exec_lock`, `exec_pc` and `exec_sp` are the values that were accepted.
- R6: While `exec_valid` is high and `exec_ready` is low, `exec_valid` stays high and every `exec_*` payload field holds its value on the next cycle.
- R7: Only one call is in service at a time. After a handoff (`exec_valid` and `exec_ready` both high), `exec_valid` stays low until `exec_done` has been seen.
- R8: An `exec_done` seen while a call is in service produces, on the next cycle, a single-cycle pulse on bit `ret_pulse[c]` only, where c is the core that made that call. In that same cycle `ret_lock` equals that call's lock address.
- R9: An `exec_done` seen while no call is in service produces no return pulse and leaves queued entries untouched. It sets `err_stray` on the next cycle.
- R10: `err_stray` stays high until reset.
- R11: The queue holds one entry per core. It keeps accepting calls from other cores while earlier calls are queued or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_valid | input | NUM_CORES | Per-core call request valid |
| call_ready | output | NUM_CORES | Per-core call accept |
| call_lock | input | NUM_CORES*16 | Lock address per core, core i at bits [16i +: 16] |
| call_pc | input | NUM_CORES*16 | Target code address per core |
| call_sp | input | NUM_CORES*16 | Stack pointer per core |
| exec_valid | output | 1 | Head entry offered to the large core |
| exec_ready | input | 1 | Large core takes the head entry |
| exec_lock | output | 16 | Lock address of the head entry |
| exec_pc | output | 16 | Target code address of the head entry |
| exec_sp | output | 16 | Stack pointer of the head entry |
| exec_core | output | 4 | Originating core of the head entry |
| exec_done | input | 1 | Large core finished the call in service |
| ret_pulse | output | NUM_CORES | One-hot return pulse to the calling core |
| ret_lock | output | 16 | Lock address echoed with the return pulse |
| err_stray | output | 1 | Sticky flag: completion seen with nothing in service |

## Verification
The hardest situation to reach is a stray completion that arrives while an entry is waiting at the head of the queue but has not been handed over. In that case the error must be raised and the waiting entry must not be consumed or routed. The bench queues one call with `exec_ready` held low, pulses `exec_done`, and then checks that the head entry is still offered with its fields intact and can still be served normally. A sweep over every non-empty set of simultaneous requesters checks the rotating priority against a pointer the bench carries from one round to the next.

// File: rtl/ccq_pkg.sv
package ccq_pkg;
  localparam int LOCK_W = 16;
  localparam int PC_W   = 16;
  localparam int SP_W   = 16;
  localparam int CORE_W = 4;

  typedef struct packed {
    logic [LOCK_W-1:0] lock;
    logic [PC_W-1:0]   pc;
    logic [SP_W-1:0]   sp;
    logic [CORE_W-1:0] core;
  } call_t;
endpackage

// File: rtl/ccq_rr_arb.sv
module ccq_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] win;
  logic          hit;
  int            idx;

  always_comb begin
    grant = '0;
    hit   = 1'b0;
    win   = last_q;
    idx   = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!hit && req[idx]) begin
        hit = 1'b1;
        win = IW'(idx);
      end
    end
    if (hit) grant[win] = 1'b1;
  end

  // a grant is always an accept, since requests are pre-qualified by valid
  always_ff @(posedge clk) begin
    if (rst)      last_q <= IW'(N - 1);
    else if (hit) last_q <= win;
  end
endmodule

// File: rtl/ccq_fifo.sv
module ccq_fifo
  import ccq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  call_t din,
  input  logic  pop,
  output call_t dout,
  output logic  empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  call_t         mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rp_q];
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/ccq_service.sv
module ccq_service
  import ccq_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LOCK_W-1:0] head_lock,
  input  logic [CORE_W-1:0] head_core,
  input  logic              done_in,
  output logic              busy,
  output logic [N-1:0]      release_v,
  output logic [N-1:0]      ret_pulse,
  output logic [LOCK_W-1:0] ret_lock,
  output logic              err
);
  logic [CORE_W-1:0] cur_core;
  logic [LOCK_W-1:0] cur_lock;

  assign release_v = (done_in && busy) ? (N'(1) << cur_core) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cur_core  <= '0;
      cur_lock  <= '0;
      ret_pulse <= '0;
      ret_lock  <= '0;
      err       <= 1'b0;
    end else begin
      ret_pulse <= release_v;
      if (done_in && busy) begin
        busy     <= 1'b0;
        ret_lock <= cur_lock;
      end else if (start) begin
        busy     <= 1'b1;
        cur_core <= head_core;
        cur_lock <= head_lock;
      end
      if (done_in && !busy) err <= 1'b1;
    end
  end
endmodule

// File: rtl/crit_call_queue.sv
module crit_call_queue
  import ccq_pkg::*;
#(
  parameter int NUM_CORES = 4   // must not exceed 2**CORE_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES-1:0]        call_valid,
  output logic [NUM_CORES-1:0]        call_ready,
  input  logic [NUM_CORES*LOCK_W-1:0] call_lock,
  input  logic [NUM_CORES*PC_W-1:0]   call_pc,
  input  logic [NUM_CORES*SP_W-1:0]   call_sp,
  output logic                        exec_valid,
  input  logic                        exec_ready,
  output logic [LOCK_W-1:0]           exec_lock,
  output logic [PC_W-1:0]             exec_pc,
  output logic [SP_W-1:0]             exec_sp,
  output logic [CORE_W-1:0]           exec_core,
  input  logic                        exec_done,
  output logic [NUM_CORES-1:0]        ret_pulse,
  output logic [LOCK_W-1:0]           ret_lock,
  output logic                        err_stray
);
  call_t                slot [NUM_CORES];
  call_t                new_entry, head;
  logic [NUM_CORES-1:0] pending_q, eligible, grant, release_v;
  logic                 accept, handoff, empty, svc_busy;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
    assign slot[i] = '{lock: call_lock[i*LOCK_W +: LOCK_W],
                       pc:   call_pc[i*PC_W +: PC_W],
                       sp:   call_sp[i*SP_W +: SP_W],
                       core: CORE_W'(i)};
  end

  assign eligible   = call_valid & ~pending_q;
  assign call_ready = grant;
  assign accept     = |grant;

  always_comb begin
    new_entry = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (grant[i]) new_entry = slot[i];
  end

  ccq_rr_arb #(.N(NUM_CORES)) u_arb (
    .clk(clk), .rst(rst), .req(eligible), .grant(grant)
  );

  ccq_fifo #(.DEPTH(NUM_CORES)) u_fifo (
    .clk(clk), .rst(rst), .push(accept), .din(new_entry),
    .pop(handoff), .dout(head), .empty(empty)
  );

  assign exec_valid = !empty && !svc_busy;
  assign handoff    = exec_valid && exec_ready;
  assign exec_lock  = head.lock;
  assign exec_pc    = head.pc;
  assign exec_sp    = head.sp;
  assign exec_core  = head.core;

  ccq_service #(.N(NUM_CORES)) u_svc (
    .clk(clk), .rst(rst), .start(handoff),
    .head_lock(head.lock), .head_core(head.core), .done_in(exec_done),
    .busy(svc_busy), .release_v(release_v), .ret_pulse(ret_pulse),
    .ret_lock(ret_lock), .err(err_stray)
  );

  always_ff @(posedge clk) begin
    if (rst) pending_q <= '0;
    else     pending_q <= (pending_q | grant) & ~release_v;
  end
endmodule

// File: rtl/ccq_checker.sv
module ccq_checker
  import ccq_pkg::*;
#(
  parameter int N = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      call_valid,
  input logic [N-1:0]      call_ready,
  input logic              exec_valid,
  input logic              exec_ready,
  input logic [LOCK_W-1:0] exec_lock,
  input logic [PC_W-1:0]   exec_pc,
  input logic [SP_W-1:0]   exec_sp,
  input logic [CORE_W-1:0] exec_core,
  input logic              exec_done,
  input logic              busy,
  input logic [N-1:0]      ret_pulse,
  input logic              err_stray
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!exec_valid && ret_pulse == '0 && !err_stray));

  assert_one_accept_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(call_valid & call_ready));

  for (genvar i = 0; i < N; i++) begin : g_core
    assert_no_second_call_R3: assert property (@(posedge clk) disable iff (rst)
      (call_valid[i] && call_ready[i]) |=> !call_ready[i]);
  end

  assert_exec_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && !exec_ready) |=> (exec_valid && $stable(exec_lock) &&
      $stable(exec_pc) && $stable(exec_sp) && $stable(exec_core)));

  assert_single_service_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && exec_ready) |=> !exec_valid);

  assert_ret_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ret_pulse));

  assert_ret_follows_done_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_pulse != '0) |-> $past(exec_done));

  assert_stray_done_R9: assert property (@(posedge clk) disable iff (rst)
    (exec_done && !busy) |=> (ret_pulse == '0 && err_stray));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err_stray |=> err_stray);
endmodule

bind crit_call_queue ccq_checker #(.N(NUM_CORES)) u_chk (
  .clk(clk), .rst(rst), .call_valid(call_valid), .call_ready(call_ready),
  .exec_valid(exec_valid), .exec_ready(exec_ready), .exec_lock(exec_lock),
  .exec_pc(exec_pc), .exec_sp(exec_sp), .exec_core(exec_core),
  .exec_done(exec_done), .busy(svc_busy), .ret_pulse(ret_pulse),
  .err_stray(err_stray)
);

// File: tb/tb_crit_call_queue.sv
module tb_crit_call_queue;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   call_valid = '0;
  logic [N-1:0]   call_ready;
  logic [N*16-1:0] call_lock = '0, call_pc = '0, call_sp = '0;
  logic           exec_valid, exec_ready = 1'b0, exec_done = 1'b0;
  logic [15:0]    exec_lock, exec_pc, exec_sp, ret_lock;
  logic [3:0]     exec_core;
  logic [N-1:0]   ret_pulse;
  logic           err_stray;

  int n_cmp = 0, n_bad = 0;
  int exp_last = N - 1;
  int order [N];
  int n_ord = 0;

  crit_call_queue #(.NUM_CORES(N)) dut (
    .clk(clk), .rst(rst), .call_valid(call_valid), .call_ready(call_ready),
    .call_lock(call_lock), .call_pc(call_pc), .call_sp(call_sp),
    .exec_valid(exec_valid), .exec_ready(exec_ready), .exec_lock(exec_lock),
    .exec_pc(exec_pc), .exec_sp(exec_sp), .exec_core(exec_core),
    .exec_done(exec_done), .ret_pulse(ret_pulse), .ret_lock(ret_lock),
    .err_stray(err_stray)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] lk(int r, int c); return 16'(16'h1000 + r*16 + c); endfunction
  function automatic logic [15:0] pcv(int r, int c); return 16'(16'h4000 + r*16 + c); endfunction
  function automatic logic [15:0] spv(int r, int c); return 16'(16'h8000 + r*16 + c); endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; presents mask m, walks the expected grant order
  task automatic offer(int m, int r);
    int rem = m;
    n_ord = 0;
    for (int c = 0; c < N; c++) begin
      call_lock[c*16 +: 16] = lk(r, c);
      call_pc[c*16 +: 16]   = pcv(r, c);
      call_sp[c*16 +: 16]   = spv(r, c);
    end
    call_valid = N'(m);
    while (rem != 0) begin
      int nxt = -1;
      #1;
      for (int k = 1; k <= N; k++) begin
        int idx = (exp_last + k) % N;
        if (nxt < 0 && rem[idx]) nxt = idx;
      end
      check("R4 rotating grant", 64'(call_ready), 64'(N'(1) << nxt));
      order[n_ord] = nxt;
      n_ord++;
      exp_last = nxt;
      rem &= ~(1 << nxt);
      @(negedge clk);
      call_valid[nxt] = 1'b0;
    end
  endtask

  task automatic serve(int c, int r);
    #1;
    check("R5 exec_valid", 64'(exec_valid), 64'd1);
    check("R5 exec_core", 64'(exec_core), 64'(c));
    check("R5 exec_lock", 64'(exec_lock), 64'(lk(r, c)));
    check("R5 exec_pc", 64'(exec_pc), 64'(pcv(r, c)));
    check("R5 exec_sp", 64'(exec_sp), 64'(spv(r, c)));
    exec_ready = 1'b1;
    @(negedge clk);
    exec_ready = 1'b0;
    #1 check("R7 no offer while in service", 64'(exec_valid), 64'd0);
    @(negedge clk);
    @(negedge clk);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    #1;
    check("R8 ret_pulse", 64'(ret_pulse), 64'(N'(1) << c));
    check("R8 ret_lock", 64'(ret_lock), 64'(lk(r, c)));
    @(negedge clk);
    #1 check("R8 single-cycle pulse", 64'(ret_pulse), 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    check("R1 exec_valid after reset", 64'(exec_valid), 64'd0);
    check("R1 ret_pulse after reset", 64'(ret_pulse), 64'd0);
    check("R1 err after reset", 64'(err_stray), 64'd0);
    check("R1 no ready without valid", 64'(call_ready), 64'd0);

    // sweep every non-empty set of simultaneous requesters (R4, R5, R11)
    for (int m = 1; m < (1 << N); m++) begin
      @(negedge clk);
      offer(m, m);
      check("R11 all queued calls held", 64'(n_ord), 64'($countones(N'(m))));
      for (int j = 0; j < n_ord; j++) serve(order[j], m);
    end

    // R3: outstanding core is held off; others still accepted (R11)
    @(negedge clk);
    offer(2, 30);
    call_valid[1] = 1'b1;
    for (int t = 0; t < 3; t++) begin
      #1 check("R3 held off while outstanding", 64'(call_ready[1]), 64'd0);
      @(negedge clk);
    end
    call_valid[1] = 1'b0;
    offer(4, 30);
    serve(1, 30);
    call_valid[1] = 1'b1;
    #1 check("R3 ready again after return", 64'(call_ready), 64'd2);
    exp_last = 1;
    @(negedge clk);
    call_valid[1] = 1'b0;
    serve(2, 30);
    serve(1, 30);

    // R9 / R10: stray completion, idle and with an entry waiting
    @(negedge clk);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    #1;
    check("R9 no pulse on stray done", 64'(ret_pulse), 64'd0);
    check("R9 error raised", 64'(err_stray), 64'd1);
    @(negedge clk);
    offer(8, 40);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    #1;
    check("R9 no pulse with entry waiting", 64'(ret_pulse), 64'd0);
    check("R9 waiting entry still offered", 64'(exec_valid), 64'd1);
    check("R9 waiting entry core intact", 64'(exec_core), 64'd3);
    serve(3, 40);
    check("R10 error sticky", 64'(err_stray), 64'd1);

    // R1: reset with an entry queued and the error set
    @(negedge clk);
    offer(1, 50);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_last = N - 1;
    #1;
    check("R1 queue emptied", 64'(exec_valid), 64'd0);
    check("R1 error cleared", 64'(err_stray), 64'd0);
    @(negedge clk);
    offer(6, 60);
    check("R1 pointer restarts at core 0 side", 64'(order[0]), 64'd1);
    serve(1, 60);
    serve(2, 60);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule